// File: doc/BRIEF.md
# Ping-Pong Transmit Byte Buffer

This block sits between a host bus and the serial transmitter of a communication controller. It holds two banks of 32 bytes. At any moment the host owns one bank and the serial engine owns the other. The host fills its bank through a write window of 32 addresses. The low five address bits play no part: each accepted write lands on the next free byte of the bank. To hand the bank over, the host pulses a commit input that carries the number of bytes to send.

When the serial engine has no work left, a committed bank swaps over to it. The host then gets the other bank, which is empty. The serial engine sends its bank one bit per bit strobe, with the most significant bit first. Bits go out in 16-bit slots, and each slot carries two consecutive bytes. When a slot has no data for it, the line is held at ones.

A ready flag tells the host that its bank can take data. An interrupt output, when enabled, follows that flag so the host is told once per bank rather than once per byte. A sticky status bit records writes that went past the end of the bank.

Top module: `txpp_buffer`

## Requirements
- R1: While reset is held and on the first cycles after reset, pool_ready is 1, tx_bit is 1, slot_start is 0, wr_ovf is 0 and irq is 0. Both banks start with nothing queued.
- R2: A host write is in the window when host_addr[7:5] equals the window tag (default 0, so 0x00 to 0x1F). Such a write stores host_data at the next byte position of the host bank, whatever host_addr[4:0] holds. A write outside the window changes nothing.
- R3: A commit is accepted while pool_ready is 1 with commit_len from 1 to 32. pool_ready reads 0 from the cycle after the commit. The bank then carries its first commit_len byte positions. It swaps to the serial side one cycle after the serial side has nothing left to send, and pool_ready reads 1 again after that swap.
- R4: A commit with commit_len of 0 or greater than 32 is ignored. pool_ready stays 1 and nothing is sent.
- R5: Each bit_en pulse puts one new bit on tx_bit at that clock edge. Slots are 16 bits long, and a slot that carries data holds the byte at position 2k in bits 15..8 and the byte at position 2k+1 in bits 7..0, each byte sent MSB first. slot_start is 1 while the first bit of a slot is on tx_bit and 0 for the other 15 bits.
- R6: When the committed length is odd, the second byte of the last slot is sent as 0xFF.
- R7: A slot that starts while the serial side has nothing to send is 16 ones.
- R8: A write in the window while the host bank already holds 32 bytes is not stored and sets wr_ovf. wr_ovf stays set until the next accepted commit clears it.
- R9: While a committed bank waits for the swap (pool_ready 0), host writes and further commits are ignored.
- R10: irq equals irq_en AND pool_ready as both stood one cycle earlier.
- R11: After each swap the host write position restarts at byte 0 of the bank the host now owns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host address; bits 7:5 select the window, bits 4:0 are ignored |
| host_data | input | 8 | Byte to store |
| commit | input | 1 | Hands the host bank to the serial side |
| commit_len | input | 6 | Number of bytes to send, 1 to 32 |
| irq_en | input | 1 | Enables the ready interrupt |
| bit_en | input | 1 | Bit strobe for the serial output |
| tx_bit | output | 1 | Serial data, MSB first |
| slot_start | output | 1 | High during the first bit of each 16-bit slot |
| pool_ready | output | 1 | Host bank may be written |
| wr_ovf | output | 1 | Sticky overflow of the host bank |
| irq | output | 1 | Ready interrupt |

## Verification
The bench mixes in-window writes with different low address bits and out-of-window writes, then sends an odd length. A design that decoded the low bits, took foreign addresses or got the padding wrong would put misplaced bytes on the line, or a data byte where the last slot should carry 0xFF. A second bank is committed while the first is still being sent, and then a write is made whose target would be a stale byte that is actually transmitted. This exposes a design that lets writes or commits through while a bank is waiting, and also one that swaps too early. Filling past 32 bytes checks the exact point where the overflow bit sets and the commit that clears it. Zero and oversize lengths must leave the line idle.

// File: rtl/txpp_pkg.sv
package txpp_pkg;

  // Ownership state of the bank currently held by the host.
  typedef enum logic {
    HB_FILL = 1'b0,  // host may write
    HB_WAIT = 1'b1   // committed, waiting for the serial side to free up
  } host_bank_e;

endpackage

// File: rtl/txpp_store.sv
module txpp_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int BPS    = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic                  wr_bank,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_bank,
  input  logic [IDX_W-1:0]      rd_base,
  output logic [BPS*DATA_W-1:0] rd_bytes
);

  logic [DATA_W-1:0] bank_mem [2][DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      bank_mem[wr_bank][wr_idx] <= wr_data;
    end
  end

  // One read port per byte of a slot; the earliest byte sits in the top lane.
  for (genvar g = 0; g < BPS; g++) begin : g_rd
    logic [IDX_W-1:0] lane_idx;
    assign lane_idx = rd_base + IDX_W'(g);
    assign rd_bytes[(BPS-1-g)*DATA_W +: DATA_W] = bank_mem[rd_bank][lane_idx];
  end

endmodule

// File: rtl/txpp_ctrl.sv
module txpp_ctrl
  import txpp_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int ADDR_W   = 8,
  parameter int WIN_BASE = 0,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = IDX_W + 1,
  localparam int TAG_W   = ADDR_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [TAG_W-1:0] host_tag,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_len,
  input  logic             irq_en,
  input  logic             ser_done,
  output logic             mem_we,
  output logic             mem_bank,
  output logic [IDX_W-1:0] mem_idx,
  output logic             ser_bank,
  output logic [CNT_W-1:0] ser_len,
  output logic             ser_start,
  output logic             ser_active,
  output logic             pool_ready,
  output logic             wr_ovf,
  output logic             irq
);

  host_bank_e       hstate_q, hstate_d;
  logic             hbank_q, hbank_d;
  logic [CNT_W-1:0] wp_q, wp_d;
  logic [CNT_W-1:0] pend_len_q, pend_len_d;
  logic [CNT_W-1:0] ser_len_q, ser_len_d;
  logic             active_q, active_d;
  logic             ovf_q, ovf_d;
  logic             irq_q, irq_d;

  logic in_win, wr_ok, ovf_set, len_ok, commit_ok, swap;

  always_comb begin
    in_win    = (host_tag == TAG_W'(WIN_BASE));
    wr_ok     = host_wr && in_win && (hstate_q == HB_FILL);
    mem_we    = wr_ok && (wp_q < CNT_W'(DEPTH));
    ovf_set   = wr_ok && (wp_q == CNT_W'(DEPTH));
    len_ok    = (commit_len != '0) && (commit_len <= CNT_W'(DEPTH));
    commit_ok = commit && len_ok && (hstate_q == HB_FILL);
    swap      = (hstate_q == HB_WAIT) && !active_q;
  end

  always_comb begin
    hstate_d   = hstate_q;
    hbank_d    = hbank_q;
    wp_d       = wp_q;
    pend_len_d = pend_len_q;
    ser_len_d  = ser_len_q;
    active_d   = active_q;
    ovf_d      = ovf_q;

    if (mem_we) begin
      wp_d = wp_q + CNT_W'(1);
    end
    if (ovf_set) begin
      ovf_d = 1'b1;
    end
    if (commit_ok) begin
      hstate_d   = HB_WAIT;
      pend_len_d = commit_len;
      ovf_d      = 1'b0;
    end
    if (ser_done) begin
      active_d = 1'b0;
    end
    if (swap) begin
      hstate_d  = HB_FILL;
      hbank_d   = ~hbank_q;
      wp_d      = '0;
      ser_len_d = pend_len_q;
      active_d  = 1'b1;
    end

    irq_d = irq_en && (hstate_q == HB_FILL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hstate_q   <= HB_FILL;
      hbank_q    <= 1'b0;
      wp_q       <= '0;
      pend_len_q <= '0;
      ser_len_q  <= '0;
      active_q   <= 1'b0;
      ovf_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      hstate_q   <= hstate_d;
      hbank_q    <= hbank_d;
      wp_q       <= wp_d;
      pend_len_q <= pend_len_d;
      ser_len_q  <= ser_len_d;
      active_q   <= active_d;
      ovf_q      <= ovf_d;
      irq_q      <= irq_d;
    end
  end

  assign mem_bank   = hbank_q;
  assign mem_idx    = wp_q[IDX_W-1:0];
  assign ser_bank   = ~hbank_q;
  assign ser_len    = ser_len_q;
  assign ser_start  = swap;
  assign ser_active = active_q;
  assign pool_ready = (hstate_q == HB_FILL);
  assign wr_ovf     = ovf_q;
  assign irq        = irq_q;

endmodule

// File: rtl/txpp_shift.sv
module txpp_shift #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 32,
  parameter int SLOT_BITS = 16,
  localparam int BPS      = SLOT_BITS / DATA_W,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = IDX_W + 1,
  localparam int SUM_W    = CNT_W + 1,
  localparam int POS_W    = $clog2(SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 ser_start,
  input  logic                 ser_active,
  input  logic [CNT_W-1:0]     ser_len,
  input  logic [SLOT_BITS-1:0] rd_bytes,
  output logic [IDX_W-1:0]     rd_base,
  output logic                 ser_done,
  output logic                 tx_bit,
  output logic                 slot_start
);

  logic [POS_W-1:0]     pos_q, pos_d;
  logic [CNT_W-1:0]     rp_q, rp_d;
  logic [SLOT_BITS-1:0] sh_q, sh_d;
  logic                 bit_q, bit_d;
  logic                 ss_q, ss_d;
  logic                 data_q, data_d;
  logic                 last_q, last_d;

  logic [SLOT_BITS-1:0] word;
  logic                 at_load, at_end;
  logic [SUM_W-1:0]     next_rp;

  // Lanes past the committed length are padded with ones.
  for (genvar g = 0; g < BPS; g++) begin : g_lane
    logic [SUM_W-1:0] lane_pos;
    assign lane_pos = SUM_W'(rp_q) + SUM_W'(g);
    assign word[(BPS-1-g)*DATA_W +: DATA_W] =
      (lane_pos < SUM_W'(ser_len)) ? rd_bytes[(BPS-1-g)*DATA_W +: DATA_W]
                                   : {DATA_W{1'b1}};
  end

  always_comb begin
    at_load = bit_en && (pos_q == '0);
    at_end  = bit_en && (pos_q == POS_W'(SLOT_BITS-1));
    next_rp = SUM_W'(rp_q) + SUM_W'(BPS);

    pos_d  = pos_q;
    rp_d   = rp_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    ss_d   = ss_q;
    data_d = data_q;
    last_d = last_q;

    if (bit_en) begin
      pos_d = at_end ? '0 : pos_q + POS_W'(1);
    end

    if (at_load) begin
      ss_d = 1'b1;
      if (ser_active) begin
        bit_d  = word[SLOT_BITS-1];
        sh_d   = {word[SLOT_BITS-2:0], 1'b1};
        rp_d   = next_rp[CNT_W-1:0];
        data_d = 1'b1;
        last_d = (next_rp >= SUM_W'(ser_len));
      end else begin
        bit_d  = 1'b1;
        sh_d   = '1;
        data_d = 1'b0;
        last_d = 1'b0;
      end
    end else if (bit_en) begin
      ss_d  = 1'b0;
      bit_d = sh_q[SLOT_BITS-1];
      sh_d  = {sh_q[SLOT_BITS-2:0], 1'b1};
    end

    if (ser_start) begin
      rp_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      rp_q   <= '0;
      sh_q   <= '1;
      bit_q  <= 1'b1;
      ss_q   <= 1'b0;
      data_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      rp_q   <= rp_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      ss_q   <= ss_d;
      data_q <= data_d;
      last_q <= last_d;
    end
  end

  assign rd_base    = rp_q[IDX_W-1:0];
  assign ser_done   = at_end && data_q && last_q;
  assign tx_bit     = bit_q;
  assign slot_start = ss_q;

endmodule

// File: rtl/txpp_buffer.sv
module txpp_buffer #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 32,
  parameter int SLOT_BITS = 16,
  parameter int ADDR_W    = 8,
  parameter int WIN_BASE  = 0,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = IDX_W + 1,
  localparam int BPS      = SLOT_BITS / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              commit,
  input  logic [CNT_W-1:0]  commit_len,
  input  logic              irq_en,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              slot_start,
  output logic              pool_ready,
  output logic              wr_ovf,
  output logic              irq
);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Address bits inside the window carry no meaning for writes.
  logic unused_low_addr;
  assign unused_low_addr = ^host_addr[IDX_W-1:0];

  logic                 mem_we, mem_bank, ser_bank;
  logic [IDX_W-1:0]     mem_idx, rd_base;
  logic [CNT_W-1:0]     ser_len;
  logic                 ser_start, ser_active, ser_done;
  logic [SLOT_BITS-1:0] rd_bytes;

  txpp_ctrl #(
    .DEPTH    (DEPTH),
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_wr    (host_wr),
    .host_tag   (host_addr[ADDR_W-1:IDX_W]),
    .commit     (commit),
    .commit_len (commit_len),
    .irq_en     (irq_en),
    .ser_done   (ser_done),
    .mem_we     (mem_we),
    .mem_bank   (mem_bank),
    .mem_idx    (mem_idx),
    .ser_bank   (ser_bank),
    .ser_len    (ser_len),
    .ser_start  (ser_start),
    .ser_active (ser_active),
    .pool_ready (pool_ready),
    .wr_ovf     (wr_ovf),
    .irq        (irq)
  );

  txpp_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .BPS    (BPS)
  ) u_store (
    .clk      (clk),
    .wr_en    (mem_we),
    .wr_bank  (mem_bank),
    .wr_idx   (mem_idx),
    .wr_data  (host_data),
    .rd_bank  (ser_bank),
    .rd_base  (rd_base),
    .rd_bytes (rd_bytes)
  );

  txpp_shift #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .SLOT_BITS (SLOT_BITS)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bit_en     (bit_en),
    .ser_start  (ser_start),
    .ser_active (ser_active),
    .ser_len    (ser_len),
    .rd_bytes   (rd_bytes),
    .rd_base    (rd_base),
    .ser_done   (ser_done),
    .tx_bit     (tx_bit),
    .slot_start (slot_start)
  );

endmodule

// File: rtl/txpp_buffer_chk.sv
module txpp_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic commit,
  input logic irq_en,
  input logic bit_en,
  input logic tx_bit,
  input logic slot_start,
  input logic pool_ready,
  input logic wr_ovf,
  input logic irq
);

  // R8
  ovf_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ovf) |-> $past(host_wr));

  // R3
  ready_drop_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pool_ready) |-> $past(commit));

  // R5
  line_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable(tx_bit));

  // R5
  slot_mark_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_start) |-> $past(bit_en));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en && pool_ready));

  // R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(irq_en && pool_ready)) |-> irq);

endmodule

bind txpp_buffer txpp_buffer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_wr    (host_wr),
  .commit     (commit),
  .irq_en     (irq_en),
  .bit_en     (bit_en),
  .tx_bit     (tx_bit),
  .slot_start (slot_start),
  .pool_ready (pool_ready),
  .wr_ovf     (wr_ovf),
  .irq        (irq)
);

// File: tb/txpp_buffer_bench.sv
module txpp_buffer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr;
  logic [7:0] host_addr;
  logic [7:0] host_data;
  logic       commit;
  logic [5:0] commit_len;
  logic       irq_en;
  logic       bit_en;
  logic       tx_bit, slot_start, pool_ready, wr_ovf, irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  txpp_buffer u_txpp_buffer (
    .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_addr (host_addr),
    .host_data (host_data), .commit (commit), .commit_len (commit_len),
    .irq_en (irq_en), .bit_en (bit_en), .tx_bit (tx_bit),
    .slot_start (slot_start), .pool_ready (pool_ready), .wr_ovf (wr_ovf),
    .irq (irq)
  );

  // {accepted, address, data}
  localparam logic [16:0] WR_VEC [10] = '{
    {1'b1, 8'h00, 8'h3C}, {1'b1, 8'h1F, 8'hA5}, {1'b0, 8'h20, 8'h11},
    {1'b1, 8'h07, 8'h00}, {1'b1, 8'h10, 8'hFF}, {1'b0, 8'hE5, 8'h22},
    {1'b1, 8'h1A, 8'h81}, {1'b1, 8'h05, 8'h5A}, {1'b0, 8'h40, 8'h33},
    {1'b1, 8'h0C, 8'hC3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_data = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic cmt(input logic [5:0] n);
    commit = 1'b1; commit_len = n;
    tick();
    commit = 1'b0;
  endtask

  task automatic check_slot(input logic [15:0] exp, input string tag);
    logic [15:0] w;
    logic [1:0]  ss;
    w = '0; ss = '0;
    for (int i = 0; i < 16; i++) begin
      bit_en = 1'b1;
      tick();
      w = {w[14:0], tx_bit};
      if (i == 0) ss[1] = slot_start;
      if (i == 1) ss[0] = slot_start;
    end
    bit_en = 1'b0;
    chk(tag, {16'h0, w}, {16'h0, exp});
    chk("R5 slot_start on first bit only", {30'h0, ss}, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_b [32];
    int nb;

    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_data = '0;
    commit = 1'b0; commit_len = '0; irq_en = 1'b0; bit_en = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 pool_ready", {31'h0, pool_ready}, 32'h1);
    chk("R1 tx_bit", {31'h0, tx_bit}, 32'h1);
    chk("R1 slot_start", {31'h0, slot_start}, 32'h0);
    chk("R1 wr_ovf", {31'h0, wr_ovf}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R10 irq follows enable and ready
    irq_en = 1'b1;
    tick();
    chk("R10 irq with ready", {31'h0, irq}, 32'h1);

    // R7 idle slot
    check_slot(16'hFFFF, "R7 idle slot");

    // R2 table walk: window decode, sequential placement
    nb = 0;
    for (int i = 0; i < 10; i++) begin
      wr(WR_VEC[i][15:8], WR_VEC[i][7:0]);
      if (WR_VEC[i][16]) begin
        exp_b[nb] = WR_VEC[i][7:0];
        nb++;
      end
    end
    cmt(6'(nb));
    chk("R3 ready low after commit", {31'h0, pool_ready}, 32'h0);
    tick();
    chk("R3 ready back after swap", {31'h0, pool_ready}, 32'h1);
    chk("R10 irq drops one cycle later", {31'h0, irq}, 32'h0);
    for (int s = 0; s < 4; s++) begin
      check_slot({exp_b[2*s], (2*s+1 < nb) ? exp_b[2*s+1] : 8'hFF},
                 "R2 R5 R6 table slot");
    end
    check_slot(16'hFFFF, "R7 idle after table bank");

    // R9 / R11: second bank waits while first is still sending
    wr(8'h03, 8'hA0); wr(8'h13, 8'hA1); wr(8'h1B, 8'hA2); wr(8'h0E, 8'hA3);
    cmt(6'd4);
    tick();
    wr(8'h11, 8'hB0); wr(8'h02, 8'hB1);
    cmt(6'd3);
    tick(); tick();
    chk("R3 bank waits while serial busy", {31'h0, pool_ready}, 32'h0);
    wr(8'h08, 8'h77);   // would land on position 2 if accepted
    cmt(6'd5);
    chk("R9 no overflow from blocked write", {31'h0, wr_ovf}, 32'h0);
    check_slot(16'hA0A1, "R5 first bank slot0");
    check_slot(16'hA2A3, "R5 first bank slot1");
    chk("R3 still waiting at last bit", {31'h0, pool_ready}, 32'h0);
    tick();
    chk("R3 ready after late swap", {31'h0, pool_ready}, 32'h1);
    check_slot(16'hB0B1, "R11 second bank starts at byte 0");
    check_slot({8'h00, 8'hFF}, "R9 stale byte kept, length kept");
    check_slot(16'hFFFF, "R9 blocked commit sent nothing");

    // R8 overflow
    for (int i = 0; i < 32; i++) wr(8'(i), 8'(i));
    chk("R8 no overflow at 32", {31'h0, wr_ovf}, 32'h0);
    wr(8'h1F, 8'hEE);
    chk("R8 overflow at 33", {31'h0, wr_ovf}, 32'h1);
    cmt(6'd32);
    chk("R8 commit clears overflow", {31'h0, wr_ovf}, 32'h0);
    tick();
    for (int s = 0; s < 16; s++) begin
      check_slot({8'(2*s), 8'(2*s+1)}, "R8 full bank slot");
    end
    check_slot(16'hFFFF, "R8 extra byte not sent");

    // R4 bad lengths
    wr(8'h00, 8'h12);
    cmt(6'd0);
    chk("R4 zero length ignored", {31'h0, pool_ready}, 32'h1);
    cmt(6'd33);
    chk("R4 oversize length ignored", {31'h0, pool_ready}, 32'h1);
    tick();
    check_slot(16'hFFFF, "R4 nothing sent");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule